// File: doc/BRIEF.md
# Structured Three-Bit Bitwise Logic Unit

This block computes one of eight bitwise functions of two operands. The 3-bit function code is not a lookup of eight separate gates. It is decoded as structure. The top bit picks one of two gate sections. The low bit always inverts that section's output. The middle bit has a different job in each section: in section 0 it inverts both operands ahead of an OR, and in section 1 it enables the ~A·B term. Every function comes from a few De Morgan rewrites of the same two gate networks, so very little logic is spent on the choice of function.

The result is cut to a lane width of 4, 8, 16 or 32 bits. A zero flag and a sign flag are produced for that lane. The datapath has no clock and no state. Operands travel on a valid/ready stream, and the stream passes straight through: the output is valid in the same cycle the input is valid, and back-pressure from the consumer reaches the producer unchanged in that cycle. A producer that sees `in_ready` low must hold its operands, function code and width steady until the transfer happens. A transfer takes place on every cycle where `in_valid` and `in_ready` are both high.

Top module: `bitlogic_unit`

## Requirements
- R1: With function code bit 2 at 0, codes 000, 001, 010 and 011 give A|B, ~(A|B), ~(A&B) and A&B.
- R2: With function code bit 2 at 1, codes 100, 110 and 111 give A&~B, A^B and ~(A^B).
- R3: Code 101 gives ~B and ignores operand A entirely: changing A does not change the result.
- R4: The width code selects the lane: 00 is 4 bits, 01 is 8 bits, 10 is 16 bits and 11 is 32 bits. Result bits above the lane are 0, and operand bits above the lane have no effect.
- R5: `out_zero` is 1 exactly when the lane-masked result is all zeros.
- R6: `out_sign` equals the top bit of the lane-masked result (bit 3, 7, 15 or 31).
- R7: `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. While a transfer is stalled, the result stays stable as long as the inputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Operands, function code and width are valid |
| in_ready | output | 1 | Unit can accept (mirrors out_ready) |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_func | input | 3 | Function code: bit 2 section, bit 1 mix, bit 0 invert |
| in_width | input | 2 | Lane width code (00=4, 01=8, 10=16, 11=32 bits) |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_result | output | 32 | Lane-masked result |
| out_zero | output | 1 | Masked result is zero |
| out_sign | output | 1 | Top bit of the lane |

## Verification
The assertions are evaluated on every input change. They cover the parts of the output that can be stated independently of the function chosen: the stream mirroring, the zero bits above the lane, the agreement of the zero and sign flags with the result, and the single-operand inverse produced by code 101. Whether each of the other seven codes really produces its stated function at each width can only be shown by the bench's scenarios. The scenarios sweep every code and width with operand patterns chosen to yield zero results, negative results and dirty high bits. The same scenarios show that the result stays stable while the consumer stalls.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;

  typedef enum logic [1:0] {
    LANE_4  = 2'd0,
    LANE_8  = 2'd1,
    LANE_16 = 2'd2,
    LANE_32 = 2'd3
  } lane_e;

  typedef struct packed {
    logic section;
    logic mix;
    logic invert;
  } func_t;

  localparam int unsigned NUM_LANES = 4;

  function automatic int unsigned lane_bits(input int unsigned code, input int unsigned data_w);
    int unsigned w;
    w = 4 << code;
    return (w > data_w) ? data_w : w;
  endfunction

endpackage

// File: rtl/bitlogic_operand_prep.sv
module bitlogic_operand_prep
  import bitlogic_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  func_t             fn_i,
  output logic [DATA_W-1:0] s0_a_o,
  output logic [DATA_W-1:0] s0_b_o,
  output logic [DATA_W-1:0] s1_a_o,
  output logic              s1_x_en_o,
  output logic              s1_y_en_o
);
  logic a_kill;

  // Section 0: the mix bit inverts both operands ahead of the OR.
  assign s0_a_o = a_i ^ {DATA_W{fn_i.mix}};
  assign s0_b_o = b_i ^ {DATA_W{fn_i.mix}};

  // Section 1: with the term enable low and inversion high, A is forced to zero.
  assign a_kill = ~fn_i.mix & fn_i.invert;
  assign s1_a_o = a_kill ? '0 : a_i;

  // A&~B term is live unless the single-operand path is chosen;
  // ~A&B term is live when enabled, or on the single-operand path.
  assign s1_x_en_o = fn_i.mix | ~fn_i.invert;
  assign s1_y_en_o = fn_i.mix | fn_i.invert;
endmodule

// File: rtl/bitlogic_gate_core.sv
module bitlogic_gate_core
  import bitlogic_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] s0_a_i,
  input  logic [DATA_W-1:0] s0_b_i,
  input  logic [DATA_W-1:0] s1_a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              s1_x_en_i,
  input  logic              s1_y_en_i,
  input  func_t             fn_i,
  output logic [DATA_W-1:0] raw_o
);
  logic [DATA_W-1:0] sec0, sec1, picked;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign sec0[i] = s0_a_i[i] | s0_b_i[i];
    assign sec1[i] = (s1_x_en_i & s1_a_i[i] & ~b_i[i]) |
                     (s1_y_en_i & ~s1_a_i[i] & b_i[i]);
  end

  assign picked = fn_i.section ? sec1 : sec0;
  assign raw_o  = picked ^ {DATA_W{fn_i.invert}};
endmodule

// File: rtl/bitlogic_lane_flags.sv
module bitlogic_lane_flags
  import bitlogic_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw_i,
  input  lane_e             lane_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o,
  output logic              sign_o
);
  logic [NUM_LANES-1:0][DATA_W-1:0] lane_mask;
  logic [NUM_LANES-1:0]             lane_top;
  logic [DATA_W-1:0]                masked;

  for (genvar m = 0; m < NUM_LANES; m++) begin : g_lane
    localparam int unsigned LW = lane_bits(m, DATA_W);
    assign lane_mask[m] = {DATA_W{1'b1}} >> (DATA_W - LW);
    assign lane_top[m]  = raw_i[LW-1];
  end

  assign masked   = raw_i & lane_mask[lane_i];
  assign result_o = masked;
  assign zero_o   = ~|masked;
  assign sign_o   = lane_top[lane_i];
endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
  import bitlogic_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [2:0]        in_func,
  input  logic [1:0]        in_width,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_zero,
  output logic              out_sign
);
  func_t             fn;
  logic [DATA_W-1:0] s0_a, s0_b, s1_a, raw;
  logic              x_en, y_en;

  assign fn = func_t'(in_func);

  bitlogic_operand_prep #(.DATA_W(DATA_W)) prep_i (
    .a_i(in_a), .b_i(in_b), .fn_i(fn),
    .s0_a_o(s0_a), .s0_b_o(s0_b), .s1_a_o(s1_a),
    .s1_x_en_o(x_en), .s1_y_en_o(y_en)
  );

  bitlogic_gate_core #(.DATA_W(DATA_W)) core_i (
    .s0_a_i(s0_a), .s0_b_i(s0_b), .s1_a_i(s1_a), .b_i(in_b),
    .s1_x_en_i(x_en), .s1_y_en_i(y_en), .fn_i(fn), .raw_o(raw)
  );

  bitlogic_lane_flags #(.DATA_W(DATA_W)) flags_i (
    .raw_i(raw), .lane_i(lane_e'(in_width)),
    .result_o(out_result), .zero_o(out_zero), .sign_o(out_sign)
  );

  // Pass-through stream: no storage, back-pressure mirrored.
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/bitlogic_unit_chk.sv
module bitlogic_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_b,
  input logic [2:0]        in_func,
  input logic [1:0]        in_width,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_zero,
  input logic              out_sign
);
  logic [DATA_W-1:0] chk_mask;
  int unsigned       chk_w;

  always_comb begin
    chk_w = 4 << in_width;
    if (chk_w > DATA_W) chk_w = DATA_W;
    chk_mask = '0;
    for (int i = 0; i < DATA_W; i++) chk_mask[i] = (i < chk_w);

    p_valid_mirror_r7: assert (out_valid == in_valid)
      else $error("out_valid does not follow in_valid");
    p_ready_mirror_r7: assert (in_ready == out_ready)
      else $error("in_ready does not follow out_ready");
    p_upper_clear_r4: assert ((out_result & ~chk_mask) == '0)
      else $error("result bits above lane are set");
    p_zero_flag_r5: assert (out_zero == (out_result == '0))
      else $error("zero flag disagrees with result");
    p_sign_flag_r6: assert (out_sign == out_result[chk_w-1])
      else $error("sign flag disagrees with lane top bit");
    p_not_b_r3: assert (in_func != 3'b101 || out_result == (~in_b & chk_mask))
      else $error("code 101 is not the inverse of B");
  end
endmodule

bind bitlogic_unit bitlogic_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .in_valid(in_valid), .in_ready(in_ready), .in_b(in_b),
  .in_func(in_func), .in_width(in_width), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result),
  .out_zero(out_zero), .out_sign(out_sign)
);

// File: tb/bitlogic_unit_tb_top.sv
module bitlogic_unit_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic          in_ready, out_valid, out_zero, out_sign;
  logic [DW-1:0] in_a = '0, in_b = '0, out_result;
  logic [2:0]    in_func = '0;
  logic [1:0]    in_width = '0;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [DW-1:0] res;
    logic          zero;
    logic          sign;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  bitlogic_unit #(.DATA_W(DW)) dut_i (
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .in_func(in_func), .in_width(in_width), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result),
    .out_zero(out_zero), .out_sign(out_sign)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                 input logic [2:0] f, input logic [1:0] w);
    exp_t e;
    logic [DW-1:0] r, m;
    int unsigned lw;
    case (f)
      3'd0: r = a | b;
      3'd1: r = ~(a | b);
      3'd2: r = ~(a & b);
      3'd3: r = a & b;
      3'd4: r = a & ~b;
      3'd5: r = ~b;
      3'd6: r = a ^ b;
      default: r = ~(a ^ b);
    endcase
    lw = 4 << w;
    m = (lw >= DW) ? '1 : ((DW'(1) << lw) - 1);
    e.res  = r & m;
    e.zero = (e.res == '0);
    e.sign = e.res[lw-1];
    e.tag  = (f < 4) ? "R1" : (f == 5) ? "R3" : "R2";
    return e;
  endfunction

  // Driver: presents one item, pushes its expectation, waits for transfer.
  task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [2:0] f, input logic [1:0] w);
    @(posedge clk); #1;
    in_a = a; in_b = b; in_func = f; in_width = w; in_valid = 1'b1;
    sb.push_back(model(a, b, f, w));
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Monitor: compares every accepted result against the queue head.
  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7 unexpected output", out_result, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_result == e.res, {e.tag, "/R4 result"}, out_result, e.res);
        check(out_zero == e.zero, "R5 zero flag", DW'(out_zero), DW'(e.zero));
        check(out_sign == e.sign, "R6 sign flag", DW'(out_sign), DW'(e.sign));
      end
    end
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", '0, '0);
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] pa [3];
    logic [DW-1:0] pb [3];
    logic [DW-1:0] held;
    pa[0] = 32'hF0F0_A5C3; pb[0] = 32'h3C3C_0FF0;
    pa[1] = 32'h0000_0000; pb[1] = 32'hFFFF_FFFF;  // zero-yield for AND, ~B
    pa[2] = 32'h1234_8888; pb[2] = 32'hABCD_0707;  // dirty high bits, sign hits

    repeat (3) @(posedge clk);
    @(negedge clk);
    // Idle state and stream mirroring (R7)
    check(out_valid == 1'b0, "R7 idle out_valid", DW'(out_valid), '0);
    check(in_ready == 1'b0, "R7 in_ready mirrors low out_ready", DW'(in_ready), '0);
    out_ready = 1'b1;
    #0.1;
    check(in_ready == 1'b1, "R7 in_ready mirrors high out_ready", DW'(in_ready), 1);

    // Sweep every code, lane and pattern (R1 R2 R3 R4 R5 R6)
    for (int f = 0; f < 8; f++)
      for (int w = 0; w < 4; w++)
        for (int p = 0; p < 3; p++)
          drive(pa[p], pb[p], 3'(f), 2'(w));

    // R3: A has no effect on code 101
    drive(32'hFFFF_FFFF, 32'h0F0F_0F0F, 3'b101, 2'd3);
    drive(32'h0000_0000, 32'h0F0F_0F0F, 3'b101, 2'd3);
    // R4: upper operand bits ignored in 4-bit lane
    drive(32'hFFFF_FFF0, 32'hAAAA_AAA0, 3'b000, 2'd0);
    // R6: sign at bit 15 only
    drive(32'h0000_8000, 32'h0000_0000, 3'b000, 2'd2);

    // R7: stall holds result stable
    @(posedge clk); #1;
    out_ready = 1'b0;
    in_a = 32'h5555_0001; in_b = 32'h00FF_00FF; in_func = 3'b110; in_width = 2'd3;
    in_valid = 1'b1;
    @(negedge clk);
    held = out_result;
    check(out_valid == 1'b1, "R7 valid during stall", DW'(out_valid), 1);
    check(in_ready == 1'b0, "R7 ready low during stall", DW'(in_ready), '0);
    @(negedge clk);
    check(out_result == held, "R7 result stable in stall", out_result, held);
    check(held == 32'h55AA_00FE, "R7/R2 stalled XOR value", held, 32'h55AA_00FE);
    @(posedge clk); #1;
    in_valid = 1'b0;
    out_ready = 1'b1;

    repeat (3) @(posedge clk);
    check(sb.size() == 0, "R7 scoreboard drained", DW'(sb.size()), '0);
    done = 1;
    finish_run();
  end
endmodule